// File: doc/BRIEF.md
# Dark Reference Black-Level Corrector

This block sits on the digitized output of a three-channel linear image sensor. Samples from the three colour channels can arrive back to back or interleaved sample by sample. Each sample carries a channel tag. A line-start marker on a sample sets that sample as position zero of its channel's line. Every channel follows a fixed layout along the line: a run of leading blank cells, then test cells, then the active pixels, then the light-shielded dark reference pixels, then trailing blank cells. By default the runs are 6, 14, 8002, 16 and 6 cells long.

The shielded pixels carry only dark-current signal. The block adds them up per channel and shifts the sum right to form a dark average, so no divider is needed. The dark cells come after the active pixels in the line. For that reason each active pixel is corrected with the average taken on the previous line of the same channel. The corrected value is the sample minus that average, and it is clamped at zero. Only active pixels leave the block flagged as picture data. Every accepted sample still produces a one-cycle-late output beat, so the downstream logic can keep its timing.

Top module: `dark_level_corrector`

## Requirements
- R1: While reset is low, and on the first sample edge after it rises, outValid, outActive and outData are all zero.
- R2: Each channel counts positions from the sample that carries inLineStart (position 0). Positions LEAD+TEST up to LEAD+TEST+ACTIVE-1 are active. The following DARK_CNT positions are dark reference. All other positions are non-active. Before a channel's first line start, all of its samples are non-active.
- R3: An active pixel's output equals its sample minus the dark average held for its own channel.
- R4: If the dark average exceeds the sample, the output is 0. The result never wraps.
- R5: The dark average is floor(sum of the DARK_CNT dark samples / DARK_CNT), formed by a right shift. It takes effect only once the last dark sample of the line has arrived.
- R6: After reset, every channel's dark average is 0. The first line of each channel is therefore passed through unchanged.
- R7: Channels keep separate position counters and separate dark averages. Interleaving samples from several channels does not change any channel's results.
- R8: A non-active sample (blank, test, dark, or past the end of the line) gives outValid=1, outActive=0 and outData=0.
- R9: Every accepted sample appears on the outputs exactly one clock later, with outChan equal to its channel tag.
- R10: A sample whose channel tag is NUM_CH or greater is ignored. It produces no output beat and does not move any channel's position, even if it carries a line-start marker.
- R11: A channel's position stops at the line length. Samples past it, sent without a new line start, are non-active. A line restarted before its last dark sample leaves the previous dark average in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe |
| inLineStart | input | 1 | This sample is position 0 of its channel's line |
| inChan | input | CH_W | Channel tag of the sample |
| inData | input | DATA_W | Digitized sample |
| outValid | output | 1 | Output beat, one cycle after an accepted sample |
| outActive | output | 1 | Output beat is a corrected active pixel |
| outChan | output | CH_W | Channel tag of the output beat |
| outData | output | DATA_W | Corrected pixel, zero on non-active beats |

## Verification
Some properties are checked by assertions on every cycle:
- A corrected pixel never exceeds the sample it came from, so a wrapped subtraction shows up at once.
- Non-active beats always carry zero data.
- Output beats follow accepted strobes exactly one cycle later, and ignored tags produce no beat.
- The position counter never passes the line length, and no cell is decoded as both active and dark.

Other behaviour only the bench scenarios can show:
- Whether each line uses the right average: the previous line's, per channel, floored, and zero after reset.
- That interleaving channels, restarting a line early and injecting bad tags leave that history intact.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef struct packed {
    logic valid;      // accepted sample this cycle
    logic active;     // sample is an active pixel
    logic darkAny;    // sample is a dark reference pixel
    logic darkFirst;  // first dark pixel of the line
    logic darkLast;   // last dark pixel of the line
  } blcStrobe_t;
endpackage

// File: rtl/blc_ctrl.sv
module blc_ctrl
  import blc_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int CH_W        = 2,
  parameter int LEAD_BLANK  = 6,
  parameter int TEST_CNT    = 14,
  parameter int ACTIVE_CNT  = 8002,
  parameter int DARK_CNT    = 16,
  parameter int TRAIL_BLANK = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inLineStart,
  input  logic [CH_W-1:0] inChan,
  output blcStrobe_t      strb
);
  localparam int ACT_START  = LEAD_BLANK + TEST_CNT;
  localparam int DARK_START = ACT_START + ACTIVE_CNT;
  localparam int DARK_END   = DARK_START + DARK_CNT;
  localparam int LINE_LEN   = DARK_END + TRAIL_BLANK;
  localparam int POS_W      = $clog2(LINE_LEN + 1);

  localparam logic [POS_W-1:0] P_ACT   = POS_W'(ACT_START);
  localparam logic [POS_W-1:0] P_DARK  = POS_W'(DARK_START);
  localparam logic [POS_W-1:0] P_DLAST = POS_W'(DARK_END - 1);
  localparam logic [POS_W-1:0] P_END   = POS_W'(LINE_LEN);
  localparam logic [CH_W:0]    CH_LIM  = (CH_W + 1)'(NUM_CH);

  logic [POS_W-1:0] pos [NUM_CH];
  logic [POS_W-1:0] posSel, curPos;
  logic             chanOk;

  assign chanOk = inValid && ({1'b0, inChan} < CH_LIM);

  always_comb begin
    posSel = P_END;
    for (int c = 0; c < NUM_CH; c++)
      if (inChan == CH_W'(c)) posSel = pos[c];
    curPos = inLineStart ? '0 : posSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) pos[c] <= P_END;
    end else if (chanOk) begin
      for (int c = 0; c < NUM_CH; c++)
        if (inChan == CH_W'(c))
          pos[c] <= (curPos == P_END) ? P_END : curPos + POS_W'(1);
    end
  end

  always_comb begin
    strb.valid     = chanOk;
    strb.active    = chanOk && (curPos >= P_ACT) && (curPos < P_DARK);
    strb.darkAny   = chanOk && (curPos >= P_DARK) && (curPos <= P_DLAST);
    strb.darkFirst = strb.darkAny && (curPos == P_DARK);
    strb.darkLast  = strb.darkAny && (curPos == P_DLAST);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_posChk
    assert_pos_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
      pos[g] <= P_END);
  end

  assert_region_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.active, strb.darkAny}));

endmodule

// File: rtl/blc_datapath.sv
module blc_datapath
  import blc_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CH_W     = 2,
  parameter int DATA_W   = 12,
  parameter int DARK_CNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  blcStrobe_t        strb,
  input  logic [CH_W-1:0]   chanIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              outValid,
  output logic              outActive,
  output logic [CH_W-1:0]   outChan,
  output logic [DATA_W-1:0] outData
);
  localparam int SHIFT = $clog2(DARK_CNT);
  localparam int ACC_W = DATA_W + SHIFT;

  logic [ACC_W-1:0]  acc [NUM_CH];
  logic [DATA_W-1:0] avg [NUM_CH];
  logic [ACC_W-1:0]  sampleExt, accSel, sumNext;
  logic [DATA_W-1:0] avgSel, corrected;

  assign sampleExt = ACC_W'(sampleIn);

  always_comb begin
    accSel = '0;
    avgSel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (chanIn == CH_W'(c)) begin
        accSel = acc[c];
        avgSel = avg[c];
      end
    sumNext   = (strb.darkFirst ? '0 : accSel) + sampleExt;
    corrected = (sampleIn >= avgSel) ? sampleIn - avgSel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        acc[c] <= '0;
        avg[c] <= '0;
      end
    end else if (strb.darkAny) begin
      for (int c = 0; c < NUM_CH; c++)
        if (chanIn == CH_W'(c)) begin
          acc[c] <= sumNext;
          if (strb.darkLast) avg[c] <= DATA_W'(sumNext >> SHIFT);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outActive <= 1'b0;
      outChan   <= '0;
      outData   <= '0;
    end else begin
      outValid  <= strb.valid;
      outActive <= strb.active;
      outChan   <= chanIn;
      outData   <= strb.active ? corrected : '0;
    end
  end

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> outData <= $past(sampleIn));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outActive) |-> outData == '0);

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.valid |=> outValid);

  assert_no_beat_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.valid |=> (!outValid && !outActive));

endmodule

// File: rtl/dark_level_corrector.sv
module dark_level_corrector
  import blc_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DATA_W      = 12,
  parameter int LEAD_BLANK  = 6,
  parameter int TEST_CNT    = 14,
  parameter int ACTIVE_CNT  = 8002,
  parameter int DARK_CNT    = 16,
  parameter int TRAIL_BLANK = 6,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLineStart,
  input  logic [CH_W-1:0]   inChan,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outActive,
  output logic [CH_W-1:0]   outChan,
  output logic [DATA_W-1:0] outData
);
  blcStrobe_t strb;

  blc_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .LEAD_BLANK(LEAD_BLANK), .TEST_CNT(TEST_CNT),
    .ACTIVE_CNT(ACTIVE_CNT), .DARK_CNT(DARK_CNT), .TRAIL_BLANK(TRAIL_BLANK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLineStart(inLineStart),
    .inChan(inChan), .strb(strb)
  );

  blc_datapath #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .DARK_CNT(DARK_CNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanIn(inChan), .sampleIn(inData),
    .outValid(outValid), .outActive(outActive), .outChan(outChan), .outData(outData)
  );
endmodule

// File: tb/dark_level_corrector_bench.sv
module dark_level_corrector_bench;
  localparam int ACT_N    = 10;
  localparam int ACT_S    = 20;            // 6 blank + 14 test
  localparam int DARK_S   = ACT_S + ACT_N; // 30
  localparam int DARK_N   = 16;
  localparam int LINE_N   = DARK_S + DARK_N + 6; // 52

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLineStart = 1'b0;
  logic [1:0]  inChan = '0;
  logic [11:0] inData = '0;
  logic        outValid, outActive;
  logic [1:0]  outChan;
  logic [11:0] outData;
  int nVec = 0, nFail = 0;

  always #4 clk = ~clk;

  dark_level_corrector #(.ACTIVE_CNT(ACT_N)) u_dark_level_corrector (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLineStart(inLineStart),
    .inChan(inChan), .inData(inData), .outValid(outValid), .outActive(outActive),
    .outChan(outChan), .outData(outData));

  // {channel, active base, dark base, expected average in force}
  localparam int VEC [8][4] = '{
    '{0, 100, 40, 0},   // R6 first line ch0
    '{1, 200,  0, 0},   // R6 first line ch1
    '{0, 100, 50, 47},  // R3/R5: 40+floor(120/16)
    '{1,   3,  9, 7},   // R4 clamp on low pixels
    '{2, 4085, 0, 0},   // R6 ch2, top of range
    '{0,  30,  0, 57},  // R4 all clamp
    '{0, 500,  0, 7},
    '{2,  20,  0, 7}
  };

  function automatic int pixData(int p, int act, int dark);
    if (p >= ACT_S && p < DARK_S) return act + (p - ACT_S);
    if (p >= DARK_S && p < DARK_S + DARK_N) return dark + (p - DARK_S);
    if (p >= 6 && p < ACT_S) return 4095;
    return 1;
  endfunction

  function automatic int expOut(int p, int act, int sub);
    int v;
    if (p < ACT_S || p >= DARK_S) return 0;
    v = act + (p - ACT_S) - sub;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic sendSample(int ch, bit ls, int d, bit expV, bit expA, int expD, string req);
    inValid = 1'b1; inLineStart = ls; inChan = 2'(ch); inData = 12'(d);
    @(negedge clk);
    inValid = 1'b0; inLineStart = 1'b0;
    nVec++;
    if (outValid !== expV || (expV && (outActive !== expA || outData !== 12'(expD)
        || outChan !== 2'(ch)))) begin
      nFail++;
      $display("FAIL %s: got v=%0b a=%0b ch=%0d d=%0d, expected v=%0b a=%0b ch=%0d d=%0d",
               req, outValid, outActive, outChan, outData, expV, expA, ch, expD);
    end
  endtask

  task automatic linePixel(int ch, int p, int act, int dark, int sub, string req);
    sendSample(ch, p == 0, pixData(p, act, dark), 1'b1,
               (p >= ACT_S && p < DARK_S), expOut(p, act, sub), req);
  endtask

  task automatic sendLine(int ch, int act, int dark, int sub, bit injectBad, string req);
    for (int p = 0; p < LINE_N; p++) begin
      if (injectBad && p == ACT_S + 2)
        sendSample(3, 1'b1, 77, 1'b0, 1'b0, 0, "R10 bad tag");
      linePixel(ch, p, act, dark, sub, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    nVec++;
    if (outValid !== 1'b0 || outActive !== 1'b0 || outData !== 12'd0) begin
      nFail++;
      $display("FAIL R1: got v=%0b a=%0b d=%0d, expected 0 0 0", outValid, outActive, outData);
    end
    rstN = 1'b1;
    // R2: before any line start, samples are non-active
    sendSample(0, 1'b0, 321, 1'b1, 1'b0, 0, "R2 pre-line");

    for (int i = 0; i < 8; i++)
      sendLine(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0, "R3 table");

    // R7: interleaved ch1/ch2 lines, averages ch1=16, ch2=7
    for (int p = 0; p < LINE_N; p++) begin
      linePixel(1, p, 300, 100, 16, "R7 interleave ch1");
      linePixel(2, p, 400, 200, 7, "R7 interleave ch2");
    end
    for (int p = 0; p < LINE_N; p++) begin
      linePixel(2, p, 400, 0, 207, "R7 interleave ch2 next");
      linePixel(1, p, 300, 0, 107, "R7 interleave ch1 next");
    end

    // R10: bad tag with line start mid-line on ch0 (avg 7)
    sendLine(0, 60, 0, 7, 1'b1, "R10 ch0 undisturbed");

    // R11: aborted ch2 line through 3 dark cells, then full line keeps avg 7
    for (int p = 0; p < DARK_S + 3; p++) linePixel(2, p, 10, 900, 7, "R11 aborted");
    sendLine(2, 300, 0, 7, 1'b0, "R11 restart keeps avg");
    // R11: samples past line end are non-active
    for (int k = 0; k < 3; k++) sendSample(2, 1'b0, 2000, 1'b1, 1'b0, 0, "R11 overlong");

    // R9/R10: idle cycle gives no beat
    @(negedge clk);
    nVec++;
    if (outValid !== 1'b0) begin
      nFail++;
      $display("FAIL R9: idle got v=%0b, expected 0", outValid);
    end

    // R1/R6: reset mid-run clears averages
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    nVec++;
    if (outValid !== 1'b0 || outData !== 12'd0) begin
      nFail++;
      $display("FAIL R1: got v=%0b d=%0d, expected 0 0", outValid, outData);
    end
    rstN = 1'b1;
    sendLine(1, 100, 0, 0, 1'b0, "R6 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule